// File: doc/BRIEF.md
# Register Zip/Unzip Sequencer

This block carries out a multi-register zip move and its inverse. A zip takes up to three source register vectors and interleaves them, element by element, into one destination vector. An unzip does the reverse and spreads one interleaved vector back over the same set of source vectors. The block takes decoded register fields as inputs. It then drives a register file: one read address with a combinational read-data return, and one write port. It moves one element on every clock.

The number of streams comes from two of the operand fields. When `f_rb` is zero, the move is a plain copy of the vector at `f_rc`. When `f_rb` is nonzero and `f_ra` is zero, two streams are interleaved. When both are nonzero, three streams are interleaved. A subvector length greater than one makes each group of that many consecutive registers travel as one unit.

Each register holds one element in its low bits. The source and destination element widths are chosen separately. A value that changes width is zero-extended or truncated, or it is clamped to the destination range when saturation is on, either as a signed or as an unsigned value.

Top module: `zip_seq`

## Requirements
- R1: With `f_rb` = 0 the move is a copy: for i < VL, register `f_rt`+i receives register `f_rc`+i. `f_ra` has no effect in this case.
- R2: With `f_rb` ≠ 0 and `f_ra` = 0, zip writes `f_rt`+2i from `f_rb`+i and `f_rt`+2i+1 from `f_rc`+i.
- R3: With `f_rb` ≠ 0 and `f_ra` ≠ 0, zip writes `f_rt`+3i from `f_rb`+i, `f_rt`+3i+1 from `f_rc`+i and `f_rt`+3i+2 from `f_ra`+i, in that order.
- R4: With subvector length S = `subvl_m1`+1, each stream element is a group of S consecutive registers. Destination index ((i·N+s)·S+j) takes source index (i·S+j) of stream s.
- R5: Unzip (`unzip`=1) applies the inverse mapping: stream register (i·S+j) of stream s receives `f_rt`+((i·N+s)·S+j). A zip followed by an unzip with the same fields restores the sources. Unzip reads the interleaved vector at consecutive addresses.
- R6: Width codes 0, 1, 2 and 3 mean 8, 16, 32 and 64 bits. The source element is the low `src_ew` bits of the register. Without saturation it is zero-extended or truncated to `dst_ew`. Register bits above the destination width are written as zero.
- R7: With `sat_en`=1 and `sat_signed`=0, a narrowing move clamps the unsigned source value to the destination maximum.
- R8: With `sat_en`=1 and `sat_signed`=1, the source is read as signed. It is clamped to the signed destination range, or sign-extended when widening, and stored in `dst_ew` bits.
- R9: Exactly one write is made per cycle. A move makes N·VL·S consecutive writes and is followed by a one-cycle `done` pulse with no write. With VL=0 the block makes no write and pulses `done` in the cycle after `start`.
- R10: `busy` is high exactly during the write cycles. A `start` while the block is not idle is ignored, and the fields are captured at the accepted `start`.
- R11: Register addresses wrap modulo the register count. A zip writes its destination at consecutive addresses.
- R12: While reset is held, `busy`, `done` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move; accepted only when idle |
| unzip | input | 1 | 0 = zip, 1 = unzip |
| f_rt | input | AW | Interleaved-vector base register |
| f_rc | input | AW | Stream register field C |
| f_rb | input | AW | Stream register field B (zero selects copy) |
| f_ra | input | AW | Stream register field A (zero selects at most two streams) |
| vl | input | VLW | Vector length |
| subvl_m1 | input | SVW | Subvector length minus one |
| src_ew | input | 2 | Source element width code |
| dst_ew | input | 2 | Destination element width code |
| sat_en | input | 1 | Saturation enable |
| sat_signed | input | 1 | Signed saturation when set |
| rd_addr | output | AW | Register read address |
| rd_data | input | XLEN | Register read data, same cycle |
| wr_en | output | 1 | Register write enable |
| wr_addr | output | AW | Register write address |
| wr_data | output | XLEN | Register write data |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle. Writes occur only while busy and form one unbroken run that ends in a single `done` pulse. Zip write addresses and unzip read addresses step by one with wraparound. No written bit lies above the captured destination width. The stream ordering, the subvector grouping, the zip/unzip round trip and the exact values after a width change or a clamp can only be shown by the bench. It compares the whole register file against a model after each scenario.

// File: rtl/zip_pkg.sv
package zip_pkg;
   typedef enum logic [1:0] {EW8 = 2'd0, EW16 = 2'd1, EW32 = 2'd2, EW64 = 2'd3} ew_e;
   typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RUN = 2'd1, ST_FIN = 2'd2} seq_st_e;

   // number of bits in an element of the given width code
   function automatic logic [6:0] ew_bits(input logic [1:0] code);
      return 7'd8 << code;
   endfunction
endpackage

// File: rtl/zip_addr_gen.sv
module zip_addr_gen #(
   parameter int AW  = 5,
   parameter int VLW = 5,
   parameter int SVW = 2,
   localparam int LW = VLW + SVW + 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load,
   input  logic           step,
   input  logic [1:0]     nways,
   input  logic [VLW-1:0] vl,
   input  logic [SVW-1:0] subvl_m1,
   input  logic           unzip,
   input  logic [AW-1:0]  rt,
   input  logic [AW-1:0]  rc,
   input  logic [AW-1:0]  rb,
   input  logic [AW-1:0]  ra,
   output logic [AW-1:0]  rd_addr,
   output logic [AW-1:0]  wr_addr,
   output logic           last
);
   logic [VLW-1:0] idx_i;
   logic [1:0]     idx_s;
   logic [SVW-1:0] idx_j;
   logic           end_j, end_s, end_i;

   assign end_j = (idx_j == subvl_m1);
   assign end_s = (idx_s == nways - 2'd1);
   assign end_i = (idx_i == VLW'(vl - VLW'(1)));
   assign last  = end_i && end_s && end_j;

   always_ff @(posedge clk) begin
      if (!rst_n || load) begin
         idx_i <= '0;
         idx_s <= '0;
         idx_j <= '0;
      end else if (step) begin
         idx_j <= end_j ? '0 : idx_j + SVW'(1);
         if (end_j) begin
            idx_s <= end_s ? 2'd0 : idx_s + 2'd1;
            if (end_s) idx_i <= idx_i + VLW'(1);
         end
      end
   end

   // stream base: a single stream takes C, otherwise B, C, A in turn
   logic [AW-1:0] base;
   always_comb begin
      unique case (idx_s)
         2'd0:    base = (nways == 2'd1) ? rc : rb;
         2'd1:    base = rc;
         default: base = ra;
      endcase
   end

   logic [LW-1:0] sub_len, grp, lin_seq, lin_str;
   assign sub_len = LW'(subvl_m1) + LW'(1);
   assign grp     = LW'(idx_i) * LW'(nways) + LW'(idx_s);
   assign lin_seq = grp * sub_len + LW'(idx_j);
   assign lin_str = LW'(idx_i) * sub_len + LW'(idx_j);

   logic [AW-1:0] seq_addr, str_addr;
   assign seq_addr = rt + lin_seq[AW-1:0];
   assign str_addr = base + lin_str[AW-1:0];

   assign rd_addr = unzip ? seq_addr : str_addr;
   assign wr_addr = unzip ? str_addr : seq_addr;
endmodule

// File: rtl/zip_elem_conv.sv
module zip_elem_conv
   import zip_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic [XLEN-1:0] src,
   input  logic [1:0]      sew,
   input  logic [1:0]      dew,
   input  logic            sat,
   input  logic            sgn,
   output logic [XLEN-1:0] dst
);
   logic [6:0]      wsrc, wdst;
   logic [XLEN-1:0] mask_s, mask_d, xu, xs;
   logic            narrow, sbit;

   assign wsrc   = ew_bits(sew);
   assign wdst   = ew_bits(dew);
   assign mask_s = {XLEN{1'b1}} >> (7'd64 - wsrc);
   assign mask_d = {XLEN{1'b1}} >> (7'd64 - wdst);
   assign xu     = src & mask_s;
   assign sbit   = src[wsrc - 7'd1];
   assign xs     = sbit ? (xu | ~mask_s) : xu;
   assign narrow = (dew < sew);

   generate
      if (HAS_SAT) begin : g_sat
         logic signed [XLEN-1:0] smax, smin;
         assign smax = signed'(mask_d >> 1);
         assign smin = ~smax;
         always_comb begin
            if (!sat) begin
               dst = xu & mask_d;
            end else if (!sgn) begin
               dst = (narrow && (xu > mask_d)) ? mask_d : xu;
            end else if (narrow && (signed'(xs) > smax)) begin
               dst = mask_d & smax;
            end else if (narrow && (signed'(xs) < smin)) begin
               dst = mask_d & smin;
            end else begin
               dst = mask_d & xs;
            end
         end
      end else begin : g_plain
         logic unused_ok;
         assign unused_ok = sat ^ sgn ^ narrow ^ (|xs);
         assign dst = xu & mask_d;
      end
   endgenerate
endmodule

// File: rtl/zip_seq.sv
module zip_seq
   import zip_pkg::*;
#(
   parameter int NREGS     = 32,
   parameter int XLEN      = 64,
   parameter int MAX_VL    = 16,
   parameter int MAX_SUBVL = 4,
   parameter bit HAS_SAT   = 1'b1,
   localparam int AW  = $clog2(NREGS),
   localparam int VLW = $clog2(MAX_VL + 1),
   localparam int SVW = $clog2(MAX_SUBVL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            unzip,
   input  logic [AW-1:0]   f_rt,
   input  logic [AW-1:0]   f_rc,
   input  logic [AW-1:0]   f_rb,
   input  logic [AW-1:0]   f_ra,
   input  logic [VLW-1:0]  vl,
   input  logic [SVW-1:0]  subvl_m1,
   input  logic [1:0]      src_ew,
   input  logic [1:0]      dst_ew,
   input  logic            sat_en,
   input  logic            sat_signed,
   output logic [AW-1:0]   rd_addr,
   input  logic [XLEN-1:0] rd_data,
   output logic            wr_en,
   output logic [AW-1:0]   wr_addr,
   output logic [XLEN-1:0] wr_data,
   output logic            busy,
   output logic            done
);
   generate
      if (NREGS != (1 << AW)) begin : g_bad_nregs
         $error("NREGS must be a power of two");
      end
      if (XLEN != 64) begin : g_bad_xlen
         $error("XLEN must be 64 to hold every element width");
      end
      if (MAX_SUBVL < 2 || MAX_SUBVL != (1 << SVW)) begin : g_bad_subvl
         $error("MAX_SUBVL must be a power of two of at least 2");
      end
   endgenerate

   seq_st_e        st;
   logic           unzip_q, sat_q, sgn_q;
   logic [AW-1:0]  rt_q, rc_q, rb_q, ra_q;
   logic [VLW-1:0] vl_q;
   logic [SVW-1:0] sv_q;
   logic [1:0]     sew_q, dew_q, nw_q;
   logic           accept, last;

   assign accept = (st == ST_IDLE) && start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         unzip_q <= 1'b0;
         sat_q   <= 1'b0;
         sgn_q   <= 1'b0;
         rt_q    <= '0;
         rc_q    <= '0;
         rb_q    <= '0;
         ra_q    <= '0;
         vl_q    <= '0;
         sv_q    <= '0;
         sew_q   <= 2'd0;
         dew_q   <= 2'd0;
         nw_q    <= 2'd1;
      end else begin
         unique case (st)
            ST_IDLE: if (start) begin
               st      <= (vl == '0) ? ST_FIN : ST_RUN;
               unzip_q <= unzip;
               sat_q   <= sat_en;
               sgn_q   <= sat_signed;
               rt_q    <= f_rt;
               rc_q    <= f_rc;
               rb_q    <= f_rb;
               ra_q    <= f_ra;
               vl_q    <= vl;
               sv_q    <= subvl_m1;
               sew_q   <= src_ew;
               dew_q   <= dst_ew;
               nw_q    <= (f_rb == '0) ? 2'd1 : ((f_ra == '0) ? 2'd2 : 2'd3);
            end
            ST_RUN:  if (last) st <= ST_FIN;
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (st == ST_RUN);
   assign done  = (st == ST_FIN);
   assign wr_en = busy;

   zip_addr_gen #(.AW(AW), .VLW(VLW), .SVW(SVW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .step     (busy),
      .nways    (nw_q),
      .vl       (vl_q),
      .subvl_m1 (sv_q),
      .unzip    (unzip_q),
      .rt       (rt_q),
      .rc       (rc_q),
      .rb       (rb_q),
      .ra       (ra_q),
      .rd_addr  (rd_addr),
      .wr_addr  (wr_addr),
      .last     (last)
   );

   zip_elem_conv #(.XLEN(XLEN), .HAS_SAT(HAS_SAT)) u_conv (
      .src (rd_data),
      .sew (sew_q),
      .dew (dew_q),
      .sat (sat_q),
      .sgn (sgn_q),
      .dst (wr_data)
   );
endmodule

// File: rtl/zip_seq_chk.sv
module zip_seq_chk #(
   parameter int AW   = 5,
   parameter int XLEN = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            busy,
   input logic            done,
   input logic            wr_en,
   input logic [AW-1:0]   wr_addr,
   input logic [AW-1:0]   rd_addr,
   input logic [XLEN-1:0] wr_data,
   input logic            unzip_q,
   input logic [1:0]      dew_q
);
   logic [XLEN-1:0] hi_mask;
   assign hi_mask = ~({XLEN{1'b1}} >> (7'd64 - (7'd8 << dew_q)));

   assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !wr_en);
   assert_write_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (wr_en || done));
   assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_write_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);
   assert_zip_dst_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && !unzip_q) |-> (wr_addr == AW'($past(wr_addr) + AW'(1))));
   assert_unzip_src_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(wr_en) && unzip_q) |-> (rd_addr == AW'($past(rd_addr) + AW'(1))));
   assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data & hi_mask) == '0));
endmodule

bind zip_seq zip_seq_chk #(.AW(AW), .XLEN(XLEN)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .busy    (busy),
   .done    (done),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .rd_addr (rd_addr),
   .wr_data (wr_data),
   .unzip_q (unzip_q),
   .dew_q   (dew_q)
);

// File: tb/tb_zip_seq.sv
`timescale 1ns/1ps
module tb_zip_seq;
   typedef struct packed {
      logic       unz;
      logic [4:0] rt, rc, rb, ra;
      logic [4:0] vl;
      logic [1:0] sv, sew, dew;
      logic       sat, sgn;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd4, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}, // R1 copy
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd7, 5'd3, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}, // R1 ra ignored
      '{1'b0, 5'd16, 5'd8, 5'd2, 5'd0, 5'd3, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}, // R2 two-way
      '{1'b0, 5'd20, 5'd5, 5'd1, 5'd9, 5'd3, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}, // R3 three-way
      '{1'b0, 5'd16, 5'd8, 5'd2, 5'd0, 5'd2, 2'd1, 2'd3, 2'd3, 1'b0, 1'b0}, // R4 groups of 2
      '{1'b0, 5'd18, 5'd6, 5'd1, 5'd11, 5'd1, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0},// R4 groups of 4
      '{1'b1, 5'd16, 5'd8, 5'd2, 5'd0, 5'd3, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}, // R5 unzip
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd4, 2'd0, 2'd3, 2'd1, 1'b0, 1'b0}, // R6 truncate
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd4, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0}, // R6 zero-extend
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd6, 2'd0, 2'd3, 2'd0, 1'b1, 1'b0}, // R7 unsigned clamp
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd6, 2'd0, 2'd2, 2'd0, 1'b1, 1'b1}, // R8 signed clamp
      '{1'b0, 5'd16, 5'd2, 5'd0, 5'd0, 5'd6, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1}, // R8 sign-extend
      '{1'b0, 5'd30, 5'd2, 5'd0, 5'd0, 5'd4, 2'd0, 2'd3, 2'd3, 1'b0, 1'b0}  // R11 wrap
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   vec_t        cur = '0;
   logic [4:0]  rd_addr, wr_addr;
   logic [63:0] rd_data, wr_data;
   logic        wr_en, busy, done;
   logic        ld = 1'b0;
   logic [63:0] rf [32];
   logic [63:0] img [32];
   logic [63:0] expv [32];
   int          nchk = 0;
   int          nbad = 0;

   always #2.5 clk = ~clk;

   zip_seq dut (
      .clk(clk), .rst_n(rst_n), .start(start), .unzip(cur.unz),
      .f_rt(cur.rt), .f_rc(cur.rc), .f_rb(cur.rb), .f_ra(cur.ra),
      .vl(cur.vl), .subvl_m1(cur.sv), .src_ew(cur.sew), .dst_ew(cur.dew),
      .sat_en(cur.sat), .sat_signed(cur.sgn),
      .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .busy(busy), .done(done)
   );

   assign rd_data = rf[rd_addr];

   always @(posedge clk) begin
      if (ld) begin
         for (int k = 0; k < 32; k++) rf[k] <= img[k];
      end else if (wr_en) begin
         rf[wr_addr] <= wr_data;
      end
   end

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_conv(input logic [63:0] v, input int sw, input int dw,
                                            input bit sat, input bit sg);
      int sb = 8 << sw;
      int db = 8 << dw;
      logic [63:0] u = (sb == 64) ? v : (v & ((64'd1 << sb) - 64'd1));
      logic [63:0] r;
      if (sat && sg) begin
         longint s  = (sb == 64) ? longint'(u) : (longint'(u << (64 - sb)) >>> (64 - sb));
         longint hi = (db == 64) ? 64'sh7FFF_FFFF_FFFF_FFFF : ((longint'(1) << (db - 1)) - 1);
         longint lo = -hi - 1;
         if (s > hi) s = hi;
         if (s < lo) s = lo;
         r = s;
      end else if (sat && db < 64 && u > ((64'd1 << db) - 64'd1)) begin
         r = (64'd1 << db) - 64'd1;
      end else begin
         r = u;
      end
      if (db < 64) r = r & ((64'd1 << db) - 64'd1);
      return r;
   endfunction

   task automatic fill_image();
      for (int k = 0; k < 32; k++)
         img[k] = (64'(k + 1) * 64'h9E37_79B9_7F4A_7C15) ^ (64'(k) << 7);
      img[3] = 64'h0000_0000_0000_0042;
      img[4] = 64'hFFFF_FFFF_FFFF_FF80;
      @(negedge clk) ld = 1'b1;
      @(negedge clk) ld = 1'b0;
   endtask

   // model of the whole move, starting from expv
   task automatic model(input vec_t v);
      int n  = (v.rb == 0) ? 1 : ((v.ra == 0) ? 2 : 3);
      int s_len = int'(v.sv) + 1;
      int b [3];
      b[0] = (n == 1) ? int'(v.rc) : int'(v.rb);
      b[1] = int'(v.rc);
      b[2] = int'(v.ra);
      for (int i = 0; i < int'(v.vl); i++)
         for (int s = 0; s < n; s++)
            for (int j = 0; j < s_len; j++) begin
               int q = (int'(v.rt) + (i * n + s) * s_len + j) % 32;
               int p = (b[s] + i * s_len + j) % 32;
               if (!v.unz) expv[q] = ref_conv(expv[p], int'(v.sew), int'(v.dew), v.sat, v.sgn);
               else        expv[p] = ref_conv(expv[q], int'(v.sew), int'(v.dew), v.sat, v.sgn);
            end
   endtask

   task automatic run(input vec_t v, input int poke_at, input vec_t poke, output int cyc, output int nw);
      @(negedge clk);
      cur = v;
      start = 1'b1;
      cyc = 0;
      nw = 0;
      while (cyc < 1000) begin
         @(negedge clk);
         cyc++;
         if (cyc == poke_at) begin
            cur = poke;
            start = 1'b1;
         end else begin
            start = 1'b0;
         end
         if (wr_en) nw++;
         if (done) break;
      end
   endtask

   task automatic compare_rf(input string req);
      int bad = 0;
      int first = -1;
      for (int k = 0; k < 32; k++)
         if (rf[k] !== expv[k]) begin
            bad++;
            if (first < 0) first = k;
         end
      if (first < 0) check(req, "register file", 64'd0, 64'd0);
      else check(req, $sformatf("register %0d", first), rf[first], expv[first]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nbad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end

   initial begin
      int cyc, nw, n, tot;
      repeat (3) @(negedge clk);
      // R12: outputs quiet during reset
      check("R12", "busy in reset", 64'(busy), 64'd0);
      check("R12", "done in reset", 64'(done), 64'd0);
      check("R12", "wr_en in reset", 64'(wr_en), 64'd0);
      rst_n = 1'b1;

      for (int t = 0; t < NV; t++) begin
         string req;
         fill_image();
         for (int k = 0; k < 32; k++) expv[k] = img[k];
         model(VT[t]);
         run(VT[t], -1, '0, cyc, nw);
         n = (VT[t].rb == 0) ? 1 : ((VT[t].ra == 0) ? 2 : 3);
         tot = n * int'(VT[t].vl) * (int'(VT[t].sv) + 1);
         req = $sformatf("vector %0d", t);
         compare_rf(req);
         check("R9", {req, " cycles to done"}, 64'(cyc), 64'(tot + 1));
         check("R9", {req, " write count"}, 64'(nw), 64'(tot));
      end

      // R9: zero length finishes at once without writing
      fill_image();
      for (int k = 0; k < 32; k++) expv[k] = img[k];
      begin
         vec_t z = VT[0];
         z.vl = 5'd0;
         run(z, -1, '0, cyc, nw);
      end
      check("R9", "vl=0 cycles", 64'(cyc), 64'd1);
      check("R9", "vl=0 writes", 64'(nw), 64'd0);
      compare_rf("R9");

      // R10: start during a move is ignored; fields stay as first captured
      fill_image();
      for (int k = 0; k < 32; k++) expv[k] = img[k];
      model(VT[3]);
      run(VT[3], 2, VT[2], cyc, nw);
      compare_rf("R10");
      check("R10", "cycles with extra start", 64'(cyc), 64'd10);

      // R5: zip then unzip with the same fields gives the zip image back
      fill_image();
      for (int k = 0; k < 32; k++) expv[k] = img[k];
      model(VT[3]);
      run(VT[3], -1, '0, cyc, nw);
      begin
         vec_t u = VT[3];
         u.unz = 1'b1;
         run(u, -1, '0, cyc, nw);
      end
      compare_rf("R5");
      check("R5", "source reg restored", rf[10], img[10]);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
   end
endmodule